// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block moves one byte at a time over a clocked serial link. Each transfer sends eight bits and takes in eight bits at the same time. The shift clock comes from one of two places. It can be an internal divider of the system clock with four selectable ratios, or it can be an external clock pin. That pin is brought into the system clock domain through a two-flop synchroniser before its edges are detected.

A small mode register sets four things:
- the divider ratio;
- the clock source;
- whether bits travel least- or most-significant first, for both directions;
- whether received bits come from the serial input pin or from the block's own output pin.

Taking received bits from the block's own output lets a single shared line carry half-duplex traffic.

Software first writes the mode. It then writes a transmit byte, and that write starts the transfer. A done flag rises once the eighth bit has been taken in, and the received byte is valid at that point.

Top module: `sync_serial_shifter`

## Requirements
- R1: The mode register resets to 0x00. Its fields are:
  - bits [1:0]: divider code;
  - bit 2: clock source, 1 = internal divider, 0 = external pin;
  - bit 3: bit order, 1 = MSB first, 0 = LSB first;
  - bit 4: receive source, 1 = own serial output, 0 = serial input pin.

  Bits [7:5] ignore writes and always read back 0.
- R2: After reset, the outputs are: done low, received byte 0x00, serial output high, serial clock high.
- R3: With the internal clock, each shift-clock half period lasts 2, 8, 16 or 32 system cycles for divider codes 00, 01, 10 and 11. These are ratios of 4, 16, 32 and 64. Done rises exactly 15 half periods after the edge that accepts the transmit write.
- R4: With the internal clock, the serial clock falls on the edge that accepts the transmit write. It then produces eight low/high pairs and stays high after the transfer.
- R5: The transmit byte goes out in the selected order: bit 0 first when LSB-first, bit 7 first when MSB-first. The serial output changes only at falling shift-clock edges (the first bit appears at the write), so it is stable at every rising edge.
- R6: Received bits are sampled at rising shift-clock edges and assembled in the selected order. The received-byte output updates only at the eighth rising edge.
- R7: With the receive source set to 1, the received byte equals the transmitted byte, whatever the serial input pin does.
- R8: With the external clock, each synchronised falling edge of the pin shifts out the next bit and each synchronised rising edge samples a bit. The eighth rising edge ends the transfer, and the serial-clock output follows the synchronised pin.
- R9: Done is low from the write until the eighth rising edge. It then goes high and stays high until the next transmit write, which clears it on the following cycle.
- R10: A transmit write during a transfer abandons that transfer and starts a fresh eight-bit one with the new byte.
- R11: A mode write in the same cycle as a transmit write takes effect for that transfer, covering both its divider ratio and its bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWe | input | 1 | Mode register write strobe |
| modeWData | input | 8 | Mode register write value |
| modeRData | output | 8 | Mode register read value |
| txWe | input | 1 | Transmit write strobe, starts a transfer |
| txData | input | 8 | Byte to transmit |
| extSclk | input | 1 | External shift clock pin |
| serIn | input | 1 | Serial input pin |
| sclkOut | output | 1 | Serial shift clock |
| serOut | output | 1 | Serial data output |
| rxData | output | 8 | Last received byte |
| done | output | 1 | Transfer-complete flag |

## Verification
Two events can land on the same clock edge: a mode write and a transmit write. The bench provokes this by switching from an LSB-first, fastest-ratio mode to an MSB-first, divide-by-16 mode in the very cycle that starts a transfer. It judges the result two ways. The completion time must match the new ratio (120 cycles rather than 30), and the bits seen on the serial output at each rising clock must follow the new order. A second collision is a transmit write landing on a transfer already in flight. Here the bench requires completion timing counted from the second write and the second byte in the received data.

// File: rtl/ssh_pkg.sv
package ssh_pkg;

  localparam int REG_W  = 8;
  localparam int MODE_W = 5;

  // Decoded view of the low mode-register bits.
  typedef struct packed {
    logic       loopIn;    // receive from own output
    logic       msbFirst;  // bit order
    logic       intClk;    // internal divider selected
    logic [1:0] rate;      // divider code
  } shift_mode_t;

  // Strobes from control to datapath, at most one edge event per cycle.
  typedef struct packed {
    logic load;  // transmit write accepted
    logic rise;  // sample a received bit
    logic fall;  // present the next transmit bit
    logic last;  // eighth rise, latch the received byte
  } shift_strobe_t;

endpackage

// File: rtl/ssh_ctrl.sv
module ssh_ctrl
  import ssh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BASE_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [REG_W-1:0]  modeWData,
  input  logic              txWe,
  input  logic              extSclk,
  output logic [REG_W-1:0]  modeRData,
  output shift_mode_t       mode,
  output shift_strobe_t     strb,
  output logic              sclkOut,
  output logic              done
);

  localparam int NUM_RATES = 4;
  localparam int MAX_HALF  = BASE_DIV << (NUM_RATES - 1);
  localparam int HALF_W    = $clog2(MAX_HALF);
  localparam int CNT_W     = $clog2(DATA_W) + 1;
  localparam logic [REG_W-1:0] WRITE_MASK = REG_W'((1 << MODE_W) - 1);

  // Mode register: unimplemented top bits are forced to zero on write.
  logic [REG_W-1:0] regQ;
  logic [REG_W-1:0] regNext;
  shift_mode_t      modeNext;

  assign regNext  = modeWe ? (modeWData & WRITE_MASK) : regQ;
  assign modeNext = shift_mode_t'(regNext[MODE_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end

  assign mode      = shift_mode_t'(regQ[MODE_W-1:0]);
  assign modeRData = regQ;

  // Half-period limits for each divider code.
  logic [HALF_W-1:0] limTab [NUM_RATES];
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
    localparam int HALF = (g == 0) ? (BASE_DIV / 2) : (BASE_DIV << g);
    assign limTab[g] = HALF_W'(HALF - 1);
  end

  // External clock synchroniser plus one history stage for edge detect.
  logic [SYNC_STAGES:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extSclk};
  end

  logic extLevel, extPrev, extRise, extFall;
  assign extLevel = syncQ[SYNC_STAGES-1];
  assign extPrev  = syncQ[SYNC_STAGES];
  assign extRise  = extLevel & ~extPrev;
  assign extFall  = ~extLevel & extPrev;

  // Transfer state.
  logic              busy;
  logic              sclkReg;
  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              tick;
  logic              edgeRise, edgeFall;

  assign tick     = busy & mode.intClk & (halfCnt == limTab[mode.rate]);
  assign edgeRise = mode.intClk ? (tick & ~sclkReg) : (busy & extRise);
  assign edgeFall = mode.intClk ? (tick &  sclkReg) : (busy & extFall);

  always_comb begin
    strb.load = txWe;
    strb.rise = ~txWe & edgeRise;
    strb.fall = ~txWe & edgeFall & (bitCnt != '0);
    strb.last = strb.rise & (bitCnt == CNT_W'(DATA_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclkReg <= 1'b1;
      halfCnt <= '0;
      bitCnt  <= '0;
      done    <= 1'b0;
    end else if (txWe) begin
      busy    <= 1'b1;
      sclkReg <= ~modeNext.intClk;
      halfCnt <= '0;
      bitCnt  <= '0;
      done    <= 1'b0;
    end else begin
      if (busy && mode.intClk) begin
        if (tick) begin
          halfCnt <= '0;
          sclkReg <= ~sclkReg;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
      if (strb.last) begin
        busy   <= 1'b0;
        bitCnt <= '0;
        done   <= 1'b1;
      end else if (strb.rise) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign sclkOut = mode.intClk ? sclkReg : extLevel;

  // R4: an internally clocked transfer starts with the clock low
  p_load_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txWe && modeNext.intClk) |=> !sclkReg);

  // R4: the internal clock is high when a transfer ends
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && mode.intClk) |-> sclkReg);

  // R8: never more than eight sampled bits per transfer
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(DATA_W));

  // R5: one edge event at most per cycle
  p_one_event_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.rise, strb.fall}));

  // R9: a write clears the flag, the last rise sets it, otherwise it holds
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    txWe |=> !done);
  p_done_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> done);
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !txWe) |=> done);

endmodule

// File: rtl/ssh_datapath.sv
module ssh_datapath
  import ssh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shift_strobe_t     strb,
  input  logic              msbFirst,
  input  logic              loopIn,
  input  logic [DATA_W-1:0] txData,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  logic              inBit;

  assign serOut = msbFirst ? txShift[DATA_W-1] : txShift[0];
  assign inBit  = loopIn ? serOut : serIn;
  assign rxNext = msbFirst ? {rxShift[DATA_W-2:0], inBit}
                           : {inBit, rxShift[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strb.load) begin
      txShift <= txData;
    end else if (strb.fall) begin
      txShift <= msbFirst ? {txShift[DATA_W-2:0], 1'b1}
                          : {1'b1, txShift[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
    end else if (strb.rise) begin
      rxShift <= rxNext;
      if (strb.last) rxData <= rxNext;
    end
  end

  // R5: transmit bits move only on a falling-edge or load strobe
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fall && !strb.load) |=> $stable(txShift));

  // R6: the received byte only changes at the eighth rise
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> $stable(rxData));

endmodule

// File: rtl/sync_serial_shifter.sv
module sync_serial_shifter
  import ssh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BASE_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [REG_W-1:0]  modeWData,
  output logic [REG_W-1:0]  modeRData,
  input  logic              txWe,
  input  logic [DATA_W-1:0] txData,
  input  logic              extSclk,
  input  logic              serIn,
  output logic              sclkOut,
  output logic              serOut,
  output logic [DATA_W-1:0] rxData,
  output logic              done
);

  shift_mode_t   mode;
  shift_strobe_t strb;

  ssh_ctrl #(
    .DATA_W(DATA_W), .BASE_DIV(BASE_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .modeWe(modeWe), .modeWData(modeWData), .txWe(txWe), .extSclk(extSclk),
    .modeRData(modeRData), .mode(mode), .strb(strb),
    .sclkOut(sclkOut), .done(done)
  );

  ssh_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .msbFirst(mode.msbFirst), .loopIn(mode.loopIn),
    .txData(txData), .serIn(serIn),
    .serOut(serOut), .rxData(rxData)
  );

endmodule

// File: tb/sync_serial_shifter_tb_top.sv
module sync_serial_shifter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWe = 1'b0;
  logic [7:0] modeWData = '0;
  logic [7:0] modeRData;
  logic       txWe = 1'b0;
  logic [7:0] txData = '0;
  logic       extSclk = 1'b1;
  logic       serIn;
  logic       sclkOut, serOut, done;
  logic [7:0] rxData;

  logic       useMon = 1'b0;
  logic       monIn = 1'b0;
  logic       drvIn = 1'b0;
  logic [7:0] monSeq = '0;
  logic       monMsb = 1'b0;
  logic [7:0] capTx = '0;

  int checks = 0;
  int fails  = 0;

  assign serIn = useMon ? monIn : drvIn;

  always #10 clk = ~clk;

  sync_serial_shifter dut_i (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWData(modeWData),
    .modeRData(modeRData), .txWe(txWe), .txData(txData), .extSclk(extSclk),
    .serIn(serIn), .sclkOut(sclkOut), .serOut(serOut), .rxData(rxData),
    .done(done)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic int halfOf(logic [1:0] code);
    case (code)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 16;
      default: return 32;
    endcase
  endfunction

  task automatic writeMode(logic [7:0] v);
    @(negedge clk);
    modeWe = 1'b1; modeWData = v;
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic waitDone(output int k);
    k = 0;
    while (!done && k < 4000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic testReset();
    check(done == 1'b0, "R2", "done", done, 0);
    check(rxData == 8'h00, "R2", "rxData", rxData, 0);
    check(serOut == 1'b1, "R2", "serOut", serOut, 1);
    check(sclkOut == 1'b1, "R2", "sclkOut", sclkOut, 1);
    check(modeRData == 8'h00, "R1", "mode reset", modeRData, 0);
  endtask

  task automatic testModeReg();
    writeMode(8'hFF);
    check(modeRData == 8'h1F, "R1", "top bits ignored", modeRData, 8'h1F);
    writeMode(8'hA6);
    check(modeRData == 8'h06, "R1", "readback", modeRData, 8'h06);
  endtask

  // Internally clocked transfer; optional same-cycle mode write and pin monitor.
  task automatic intXfer(string req, logic [7:0] modeVal, bit sameCycle,
                         logic [7:0] txByte, logic [7:0] inPat, bit monitor);
    int k;
    int expCyc;
    logic [7:0] expRx;
    expCyc = 15 * halfOf(modeVal[1:0]);
    expRx  = modeVal[4] ? txByte : inPat;
    if (!sameCycle) writeMode(modeVal);
    @(negedge clk);
    useMon = monitor;
    monSeq = inPat;
    monMsb = modeVal[3];
    if (monitor) begin
      fork
        for (int b = 0; b < 8; b++) begin
          @(negedge sclkOut);
          monIn = monMsb ? monSeq[7-b] : monSeq[b];
          @(posedge sclkOut);
          capTx[b] = serOut;
        end
      join_none
    end
    txWe = 1'b1; txData = txByte;
    if (sameCycle) begin modeWe = 1'b1; modeWData = modeVal; end
    @(negedge clk);
    txWe = 1'b0; modeWe = 1'b0;
    check(sclkOut == 1'b0, "R4", {req, " clock low at start"}, sclkOut, 0);
    check(done == 1'b0, "R9", {req, " done cleared"}, done, 0);
    waitDone(k);
    check(k == expCyc, "R3", {req, " cycles to done"}, k, expCyc);
    check(rxData == expRx, modeVal[4] ? "R7" : "R6", {req, " rx byte"},
          rxData, expRx);
    if (monitor)
      check(capTx == (modeVal[3] ? rev8(txByte) : txByte), "R5",
            {req, " tx order"}, capTx, modeVal[3] ? rev8(txByte) : txByte);
    repeat (3) @(negedge clk);
    check(sclkOut == 1'b1, "R4", {req, " idle high"}, sclkOut, 1);
    useMon = 1'b0;
  endtask

  task automatic testRestart();
    int k;
    writeMode(8'h14);
    @(negedge clk); txWe = 1'b1; txData = 8'h11;
    @(negedge clk); txWe = 1'b0;
    repeat (12) @(negedge clk);
    txWe = 1'b1; txData = 8'hEE;
    @(negedge clk); txWe = 1'b0;
    check(done == 1'b0, "R10", "done low after restart", done, 0);
    waitDone(k);
    check(k == 30, "R10", "cycles from second write", k, 30);
    check(rxData == 8'hEE, "R10", "second byte received", rxData, 8'hEE);
  endtask

  task automatic extXfer(string req, logic [7:0] modeVal,
                         logic [7:0] txByte, logic [7:0] inPat);
    logic [7:0] expTx;
    expTx = modeVal[3] ? rev8(txByte) : txByte;
    writeMode(modeVal);
    @(negedge clk); txWe = 1'b1; txData = txByte;
    @(negedge clk); txWe = 1'b0;
    for (int b = 0; b < 8; b++) begin
      extSclk = 1'b0;
      drvIn = modeVal[3] ? inPat[7-b] : inPat[b];
      repeat (5) @(negedge clk);
      if (b == 0) check(sclkOut == 1'b0, "R8", {req, " clock follows pin"},
                        sclkOut, 0);
      if (b == 7) check(done == 1'b0, "R9", {req, " done before last rise"},
                        done, 0);
      capTx[b] = serOut;
      extSclk = 1'b1;
      repeat (5) @(negedge clk);
    end
    check(done == 1'b1, "R8", {req, " done after eighth rise"}, done, 1);
    check(rxData == inPat, "R8", {req, " rx byte"}, rxData, inPat);
    check(capTx == expTx, "R5", {req, " tx order"}, capTx, expTx);
  endtask

  task automatic testDoneHold();
    logic [7:0] held;
    held = rxData;
    repeat (40) @(negedge clk);
    check(done == 1'b1, "R9", "done held", done, 1);
    check(rxData == held, "R6", "rx held", rxData, held);
    txWe = 1'b1; txData = 8'h00;
    @(negedge clk); txWe = 1'b0;
    check(done == 1'b0, "R9", "done cleared by write", done, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testModeReg();
    // R3 R5 R6: LSB first, divide by 4
    intXfer("int lsb r0", 8'h04, 1'b0, 8'hA5, 8'h3C, 1'b1);
    // R3 R5 R6: MSB first, divide by 16
    intXfer("int msb r1", 8'h0D, 1'b0, 8'h96, 8'hC1, 1'b1);
    // R7: own output as receive source, pin held opposite
    drvIn = 1'b1;
    intXfer("loop r2", 8'h16, 1'b0, 8'h00, 8'hFF, 1'b0);
    drvIn = 1'b0;
    intXfer("loop r3", 8'h1F, 1'b0, 8'h5A, 8'h00, 1'b0);
    // R11: mode change lands with the transmit write
    writeMode(8'h04);
    intXfer("R11 same cycle", 8'h0D, 1'b1, 8'h81, 8'h7E, 1'b1);
    testRestart();
    extXfer("ext lsb", 8'h00, 8'h4B, 8'hD2);
    extXfer("ext msb", 8'h08, 8'h2D, 8'h99);
    testDoneHold();
    finishRun();
  end

endmodule